// File: doc/BRIEF.md
# Variable-Page TLB Lookup Unit

This block searches a fully associative set of translation entries for a virtual address and reports the outcome one cycle later. Each entry holds a tag word, a data word and an 8-bit owner ID. The tag word carries the entry's own page size, which can be anywhere from 1 KB to 16 MB. The data word carries the physical page number, the entry's write and execute rights and a zone selector. A request gives the virtual address, the access kind (read, write or fetch) and a user/supervisor flag. The current process ID and a 32-bit zone-rights word qualify the search.

All entries are compared in parallel. An entry qualifies when it is valid, its page covers the address, its owner ID fits the current process, and its zone does not hide it from the requester. The lowest-numbered qualifying entry decides the result: a hit with the entry's page data, or a protection fault when its effective rights forbid the access. When no entry qualifies, the result is a miss. Entries are loaded through a plain one-entry-per-cycle write port.

Top module: `tlb_lookup_unit`

## Requirements
- R1: Tag word bits [9:7] hold a size code, where codes 0..7 mean 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB. Address and tag bits [31:10] are compared only at or above bit 10+2*code.
- R2: An entry takes part only when its tag word bit 6 (valid) is 1. An entry written with bit 6 clear is never selected.
- R3: An entry whose owner ID is zero matches any process ID. A nonzero owner ID matches only when it equals cur_pid.
- R4: Data word bits [7:4] select zone z, whose 2-bit code is zone_prot[31-2z:30-2z]. Code 0 hides the entry from user requests (req_user=1), and the search continues past it. Code 1 applies the entry's own rights.
- R5: Code 2 grants write and execute to supervisor requests only. Code 3 grants write and execute to every request.
- R6: A zone selector above ZONE_COUNT is treated as code 1. With ZONES_ON=0, every entry uses code 1.
- R7: Reads are always allowed on a qualifying entry. A write (req_kind 1) without effective write right, or a fetch (req_kind 2) without effective execute right, gives a protection fault. req_kind 3 is treated as a read.
- R8: When several entries qualify, the lowest index decides the result, including index ENTRIES-1 when it is the only one.
- R9: rsp_valid is high exactly in the cycle after a cycle with req_valid high. rsp_status is 0 for a miss, 1 for a protection fault and 2 for a hit. On a miss, every other result field is zero.
- R10: On a hit, rsp_idx is the entry index and rsp_page_base is the tag's page number masked to the page size. rsp_ppn is data bits [31:10] (with low bits zero) ANDed with PA_MASK, and rsp_size is the size code. On a fault, only rsp_idx is nonzero.
- R11: A write on the entry port (wr_en, wr_idx) replaces that entry's tag, data and owner ID, and the next request sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all entries |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry being written |
| wr_tag | input | 32 | Tag word: page number [31:10], size [9:7], valid [6] |
| wr_data | input | 32 | Data word: physical page [31:10], exec [9], write [8], zone [7:4] |
| wr_tid | input | 8 | Owner ID for the entry |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Sixteen 2-bit zone codes, zone 0 at the top |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_status | output | 2 | 0 miss, 1 protection fault, 2 hit |
| rsp_idx | output | IDX_W | Deciding entry index |
| rsp_page_base | output | 32 | Page base of the hit entry |
| rsp_ppn | output | 32 | Physical page, masked by PA_MASK |
| rsp_size | output | 3 | Size code of the hit entry |

## Verification
The embedded assertions check every cycle that a result follows each request by one cycle and never appears otherwise. They also check that status codes stay legal, that a miss carries zeroed fields, that physical pages never have bits outside PA_MASK, that page bases are aligned to their size, and that the picker grants a single qualifying entry. The bench's scenarios are the only way to show that the semantic decisions are correct. These include owner-ID filtering, zone hiding for user requests, grants per zone code, the out-of-range selector fallback, masking per size down to the 1 KB boundary, faults on write and fetch, and which overlapping entry wins.

// File: rtl/tlb_lookup_pkg.sv
// Package: shared constants, field positions and types of the TLB lookup unit.
// Assumes 32-bit tag and data words with a 1 KB minimum page.
package tlb_lookup_pkg;

    localparam int WORD_W       = 32;
    localparam int TID_W        = 8;
    localparam int SZ_W         = 3;
    localparam int ZSEL_W       = 4;
    localparam int ZSLOTS       = 1 << ZSEL_W;
    localparam int MIN_PAGE_LG  = 10;
    localparam int PN_LO        = 10;
    localparam int TAG_VALID    = 6;
    localparam int TAG_SZ_LO    = 7;
    localparam int DATA_WR      = 8;
    localparam int DATA_EX      = 9;
    localparam int DATA_ZSEL_LO = 4;

    typedef enum logic [1:0] {
        ST_MISS = 2'd0,
        ST_PROT = 2'd1,
        ST_HIT  = 2'd2
    } tlb_status_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } tlb_access_e;

    // Mask that keeps the address bits at or above the page boundary of a size code.
    function automatic logic [WORD_W-1:0] page_keep_mask(input logic [SZ_W-1:0] code);
        logic [WORD_W-1:0] ones;
        ones = '1;
        return ones << (MIN_PAGE_LG + 2 * int'(code));
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage: parallel tag, data and owner-ID register arrays.
// One entry can be written per cycle. Reset clears every entry, so no entry is valid.
module tlb_entry_store
    import tlb_lookup_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [WORD_W-1:0]              wr_tag,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [TID_W-1:0]               wr_tid,
    output logic [ENTRIES-1:0][WORD_W-1:0] tag_q,
    output logic [ENTRIES-1:0][WORD_W-1:0] data_q,
    output logic [ENTRIES-1:0][TID_W-1:0]  tid_q
);

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        // Per-slot register update: load on a matching write, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[gi]  <= '0;
                data_q[gi] <= '0;
                tid_q[gi]  <= '0;
            end else if (wr_en && (int'(wr_idx) == gi)) begin
                tag_q[gi]  <= wr_tag;
                data_q[gi] <= wr_data;
                tid_q[gi]  <= wr_tid;
            end
        end
    end

    // R11: a write from the previous cycle is visible in the addressed slot.
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |->
            (tag_q[$past(wr_idx)] == $past(wr_tag)) &&
            (data_q[$past(wr_idx)] == $past(data_q[$past(wr_idx)]) || data_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/tlb_entry_match.sv
// Single-entry qualifier. It applies the size-masked address compare, the owner-ID
// filter and the zone code, and reports whether the entry qualifies and what
// effective write and execute rights it carries. Purely combinational.
module tlb_entry_match
    import tlb_lookup_pkg::*;
#(
    parameter int ZONE_COUNT = 11,
    parameter bit ZONES_ON   = 1'b1
) (
    input  logic [WORD_W-1:0] tag,
    input  logic [WORD_W-1:0] data,
    input  logic [TID_W-1:0]  tid,
    input  logic [WORD_W-1:0] va,
    input  logic [TID_W-1:0]  pid,
    input  logic [WORD_W-1:0] zone_prot,
    input  logic              user,
    output logic              qualify,
    output logic              wr_ok,
    output logic              ex_ok
);

    logic [WORD_W-1:0] keep;
    logic              addr_eq;
    logic              tid_eq;
    logic [ZSEL_W-1:0] zsel;
    logic [5:0]        zbit;
    logic [WORD_W-1:0] zshift;
    logic [1:0]        zcode;

    // Address compare above the entry's own page boundary.
    always_comb begin
        keep    = page_keep_mask(tag[TAG_SZ_LO +: SZ_W]);
        addr_eq = ((va ^ tag) & keep) == '0;
    end

    // Owner-ID filter: zero owner is a wildcard.
    always_comb tid_eq = (tid == '0) || (tid == pid);

    // Zone code lookup with the out-of-range and disabled fallbacks to code 1.
    always_comb begin
        zsel   = data[DATA_ZSEL_LO +: ZSEL_W];
        zbit   = 6'(2 * (ZSLOTS - 1 - int'(zsel)));
        zshift = zone_prot >> zbit;
        zcode  = zshift[1:0];
        if (!ZONES_ON || (int'(zsel) > ZONE_COUNT)) begin
            zcode = 2'd1;
        end
    end

    // Qualification and effective rights after the zone override.
    always_comb begin
        qualify = tag[TAG_VALID] && addr_eq && tid_eq && !((zcode == 2'd0) && user);
        wr_ok   = data[DATA_WR] || (zcode == 2'd3) || ((zcode == 2'd2) && !user);
        ex_ok   = data[DATA_EX] || (zcode == 2'd3) || ((zcode == 2'd2) && !user);
    end

endmodule

// File: rtl/tlb_first_match.sv
// Priority picker: finds the lowest-index set bit of the qualify vector.
// It gives its index and a one-hot grant, built by two separate paths.
module tlb_first_match #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     sel_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    // Index path: scan from the top so the lowest set bit wins last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel_vec[i]) idx = IDX_W'(i);
        end
    end

    // Grant path: isolate the lowest set bit arithmetically.
    always_comb begin
        grant = sel_vec & (~sel_vec + N'(1));
        found = |sel_vec;
    end

    // R8: a single grant, only on a qualifying entry.
    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~sel_vec) == '0));
    // R8: the index path and the grant path agree on the winner.
    a_r8_paths_agree: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> grant[idx]);

endmodule

// File: rtl/tlb_lookup_unit.sv
// Top of the TLB lookup unit. It holds the entry store, one qualifier per entry and
// the priority picker, and registers the result one cycle after each request.
// Assumes requests are independent and need no backpressure.
module tlb_lookup_unit
    import tlb_lookup_pkg::*;
#(
    parameter int          ENTRIES    = 64,
    parameter int          IDX_W      = $clog2(ENTRIES),
    parameter int          ZONE_COUNT = 11,
    parameter bit          ZONES_ON   = 1'b1,
    parameter logic [31:0] PA_MASK    = 32'h0FFF_FC00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_tag,
    input  logic [31:0]      wr_data,
    input  logic [7:0]       wr_tid,
    input  logic [7:0]       cur_pid,
    input  logic [31:0]      zone_prot,
    input  logic             req_valid,
    input  logic [31:0]      req_va,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [IDX_W-1:0] rsp_idx,
    output logic [31:0]      rsp_page_base,
    output logic [31:0]      rsp_ppn,
    output logic [2:0]       rsp_size
);

    localparam logic [WORD_W-1:0] PN_MASK = {{(WORD_W-PN_LO){1'b1}}, {PN_LO{1'b0}}};

    logic [ENTRIES-1:0][WORD_W-1:0] tag_q;
    logic [ENTRIES-1:0][WORD_W-1:0] data_q;
    logic [ENTRIES-1:0][TID_W-1:0]  tid_q;
    logic [ENTRIES-1:0]             qual_vec;
    logic [ENTRIES-1:0]             wr_vec;
    logic [ENTRIES-1:0]             ex_vec;
    logic [ENTRIES-1:0]             grant;
    logic                           found;
    logic [IDX_W-1:0]               win_idx;

    tlb_status_e       nx_status;
    logic [WORD_W-1:0] nx_base;
    logic [WORD_W-1:0] nx_ppn;
    logic [SZ_W-1:0]   nx_size;
    logic [IDX_W-1:0]  nx_idx;
    logic [WORD_W-1:0] win_tag;
    logic [WORD_W-1:0] win_data;

    tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_data (wr_data),
        .wr_tid  (wr_tid),
        .tag_q   (tag_q),
        .data_q  (data_q),
        .tid_q   (tid_q)
    );

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cell
        tlb_entry_match #(.ZONE_COUNT(ZONE_COUNT), .ZONES_ON(ZONES_ON)) u_match (
            .tag       (tag_q[gi]),
            .data      (data_q[gi]),
            .tid       (tid_q[gi]),
            .va        (req_va),
            .pid       (cur_pid),
            .zone_prot (zone_prot),
            .user      (req_user),
            .qualify   (qual_vec[gi]),
            .wr_ok     (wr_vec[gi]),
            .ex_ok     (ex_vec[gi])
        );
    end

    tlb_first_match #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_vec (qual_vec),
        .found   (found),
        .idx     (win_idx),
        .grant   (grant)
    );

    // Result decode for the winning entry: hit, fault or miss, with fields.
    always_comb begin
        win_tag   = tag_q[win_idx];
        win_data  = data_q[win_idx];
        nx_status = ST_MISS;
        nx_base   = '0;
        nx_ppn    = '0;
        nx_size   = '0;
        nx_idx    = '0;
        if (found) begin
            nx_idx = win_idx;
            if (((req_kind == ACC_WRITE) && !wr_vec[win_idx]) ||
                ((req_kind == ACC_FETCH) && !ex_vec[win_idx])) begin
                nx_status = ST_PROT;
            end else begin
                nx_status = ST_HIT;
                nx_size   = win_tag[TAG_SZ_LO +: SZ_W];
                nx_base   = win_tag & page_keep_mask(nx_size);
                nx_ppn    = win_data & PN_MASK & PA_MASK;
            end
        end
    end

    // Result register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_status    <= ST_MISS;
            rsp_idx       <= '0;
            rsp_page_base <= '0;
            rsp_ppn       <= '0;
            rsp_size      <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_status    <= nx_status;
                rsp_idx       <= nx_idx;
                rsp_page_base <= nx_base;
                rsp_ppn       <= nx_ppn;
                rsp_size      <= nx_size;
            end
        end
    end

    // R9: every request yields a result in the next cycle.
    a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R9: no result appears without a request.
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9: status code stays within the three defined values.
    a_r9_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));
    // R9: a miss carries all-zero fields.
    a_r9_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_MISS) |->
            (rsp_idx == '0 && rsp_ppn == '0 && rsp_page_base == '0 && rsp_size == '0));
    // R10: the physical page never has bits outside the configured mask.
    a_r10_ppn_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ppn & ~PA_MASK) == '0);
    // R10: a hit's page base is aligned to its reported size.
    a_r10_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_HIT) |->
            ((rsp_page_base & ~page_keep_mask(rsp_size)) == '0));

endmodule

// File: tb/tlb_lookup_unit_bench.sv
// Scoreboard bench: the driver pushes expected results computed from the
// requirements, and the monitor pops and compares them as results appear.
module tlb_lookup_unit_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 64;
    localparam int          IW         = 6;
    localparam int          ZC         = 11;
    localparam logic [31:0] PAM        = 32'h0FFF_FC00;

    typedef struct packed {
        logic [1:0]    st;
        logic [IW-1:0] idx;
        logic [31:0]   base;
        logic [31:0]   ppn;
        logic [2:0]    sz;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [31:0]   wr_tag = '0;
    logic [31:0]   wr_data = '0;
    logic [7:0]    wr_tid = '0;
    logic [7:0]    cur_pid = '0;
    logic [31:0]   zone_prot = '0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_va = '0;
    logic [1:0]    req_kind = '0;
    logic          req_user = 1'b0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [IW-1:0] rsp_idx;
    logic [31:0]   rsp_page_base;
    logic [31:0]   rsp_ppn;
    logic [2:0]    rsp_size;

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0] m_tag  [N];
    logic [31:0] m_data [N];
    logic [7:0]  m_tid  [N];

    tlb_lookup_unit #(.ENTRIES(N), .IDX_W(IW), .ZONE_COUNT(ZC), .ZONES_ON(1'b1), .PA_MASK(PAM)) u_tlb_lookup_unit (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
        .wr_tag (wr_tag), .wr_data (wr_data), .wr_tid (wr_tid),
        .cur_pid (cur_pid), .zone_prot (zone_prot), .req_valid (req_valid),
        .req_va (req_va), .req_kind (req_kind), .req_user (req_user),
        .rsp_valid (rsp_valid), .rsp_status (rsp_status), .rsp_idx (rsp_idx),
        .rsp_page_base (rsp_page_base), .rsp_ppn (rsp_ppn), .rsp_size (rsp_size)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference result taken from the written requirements.
    function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind, input logic user);
        exp_t r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] t, d, keep;
            int sh, sel;
            logic [1:0] code;
            logic w, x;
            t = m_tag[i];
            d = m_data[i];
            if (!t[6]) continue;
            sh = 10 + 2 * int'(t[9:7]);
            keep = 32'hFFFF_FFFF << sh;
            if ((va & keep) != (t & keep)) continue;
            if (m_tid[i] != 0 && m_tid[i] != cur_pid) continue;
            sel = int'(d[7:4]);
            code = 2'((zone_prot >> (30 - 2 * sel)) & 32'd3);
            if (sel > ZC) code = 2'd1;
            w = d[8];
            x = d[9];
            if (code == 2'd0 && user) continue;
            if (code == 2'd3 || (code == 2'd2 && !user)) begin
                w = 1'b1;
                x = 1'b1;
            end
            r.idx = IW'(i);
            if ((kind == 2'd1 && !w) || (kind == 2'd2 && !x)) begin
                r.st = 2'd1;
            end else begin
                r.st   = 2'd2;
                r.base = t & keep;
                r.ppn  = {d[31:10], 10'b0} & PAM;
                r.sz   = t[9:7];
            end
            return r;
        end
        return r;
    endfunction

    task automatic load(input int idx, input logic [31:0] t, input logic [31:0] d, input logic [7:0] id);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en   = 1'b1;
        wr_idx  = IW'(idx);
        wr_tag  = t;
        wr_data = d;
        wr_tid  = id;
        m_tag[idx]  = t;
        m_data[idx] = d;
        m_tid[idx]  = id;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic user, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        req_kind  = kind;
        req_user  = user;
        exp_q.push_back(model(va, kind, user));
        tag_q.push_back(rq);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each result with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            string rq;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9: unexpected result status=%0d, expected none", rsp_status);
            end else begin
                e  = exp_q.pop_front();
                rq = tag_q.pop_front();
                if (rsp_status != e.st || rsp_idx != e.idx || rsp_page_base != e.base ||
                    rsp_ppn != e.ppn || rsp_size != e.sz) begin
                    fails++;
                    $display("FAIL %s: got st=%0d idx=%0d base=%h ppn=%h sz=%0d, expected st=%0d idx=%0d base=%h ppn=%h sz=%0d",
                             rq, rsp_status, rsp_idx, rsp_page_base, rsp_ppn, rsp_size,
                             e.st, e.idx, e.base, e.ppn, e.sz);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0; m_data[i] = '0; m_tid[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_status !== 2'd0) begin
            fails++;
            $display("FAIL R9: reset state valid=%b status=%0d, expected 0/0", rsp_valid, rsp_status);
        end
        // zones: z0=1 z1=1 z2=0 z3=2 z4=3 z13=3
        zone_prot = 32'h52C0_0030;
        cur_pid   = 8'd5;
        load(0,  32'h0001_00C0, 32'hF123_4110, 8'd0);   // 4KB, wr, zone1
        load(1,  32'h0300_03C0, 32'h0ABC_0200, 8'd5);   // 16MB, ex, tid 5
        load(2,  32'h2000_0440, 32'h1234_0320, 8'd0);   // 1KB, wr ex, zone2 (code0)
        load(3,  32'h2000_01C0, 32'h4567_0030, 8'd0);   // 64KB, zone3 (code2)
        load(4,  32'h4000_0240, 32'h5555_0040, 8'd0);   // 256KB, zone4 (code3)
        load(5,  32'h5000_00C0, 32'h6666_00D0, 8'd0);   // zone13 out of range
        load(6,  32'h6000_0280, 32'h7777_0300, 8'd0);   // invalid
        load(7,  32'h7000_0140, 32'h1111_0110, 8'd0);   // 16KB overlap, low index
        load(9,  32'h7000_00C0, 32'h2222_0310, 8'd0);   // 4KB overlap, high index
        load(63, 32'h8000_00C0, 32'h3333_0310, 8'd9);   // last slot, tid 9

        lookup(32'h0001_0ABC, 2'd0, 1'b0, "R1 4KB read hit");
        lookup(32'h0001_1000, 2'd0, 1'b0, "R1 beyond 4KB miss");
        lookup(32'h0001_0004, 2'd1, 1'b0, "R7 write to writable");
        lookup(32'h0001_0004, 2'd2, 1'b0, "R7 fetch non-exec fault");
        lookup(32'h0001_0004, 2'd3, 1'b0, "R7 kind3 as read");
        lookup(32'h03FF_FFFC, 2'd2, 1'b1, "R1 R3 16MB tid match fetch");
        lookup(32'h0300_1234, 2'd1, 1'b1, "R7 write non-writable fault");
        lookup(32'h2000_0410, 2'd0, 1'b1, "R4 zone0 hides from user");
        lookup(32'h2000_0410, 2'd1, 1'b1, "R5 code2 user write fault");
        lookup(32'h2000_0410, 2'd1, 1'b0, "R4 R8 code0 supervisor own rights");
        lookup(32'h2000_1000, 2'd1, 1'b0, "R5 code2 supervisor grant");
        lookup(32'h2000_0800, 2'd0, 1'b0, "R1 1KB boundary");
        lookup(32'h4003_FFF0, 2'd2, 1'b1, "R5 code3 user fetch");
        lookup(32'h5000_0000, 2'd1, 1'b0, "R6 out of range zone fault");
        lookup(32'h6000_0000, 2'd0, 1'b0, "R2 invalid entry miss");
        lookup(32'h7000_0100, 2'd0, 1'b0, "R8 lowest index wins");
        lookup(32'h8000_0010, 2'd0, 1'b0, "R3 R8 tid mismatch miss");
        idle();
        cur_pid = 8'd9;
        lookup(32'h8000_0010, 2'd2, 1'b0, "R8 R10 last slot hit");
        idle();
        cur_pid = 8'd6;
        lookup(32'h0300_1234, 2'd0, 1'b0, "R3 tid ignored for other pid");
        idle();
        load(0, 32'h0001_0080, 32'hF123_4110, 8'd0);     // rewrite without valid
        lookup(32'h0001_0ABC, 2'd0, 1'b0, "R11 R2 rewritten entry miss");
        load(0, 32'h00AB_C0C0, 32'hFFFF_F310, 8'd0);     // new page
        lookup(32'h00AB_CFFF, 2'd2, 1'b0, "R11 R10 new contents ppn masked");
        idle();
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule